// File: doc/BRIEF.md
# Free-Running Counter with Phase-Gated Count Strobes

This block is a small synchronous binary counter that runs continuously from the moment its reset is released. Every counter bit changes on the falling edge of the clock. A set of comparators watches the count. Each one drives its own strobe output when the count holds a chosen value: 2, 3 or 5.

Each strobe is the comparator result ANDed with the inverted clock. As a result, a strobe is high only in the low half of the cycle in which the count matches. The count bits settle at the falling edge, so each strobe fills the low phase that follows them, lasts half a clock period, and is quiet for the whole high phase.

A width parameter also selects a 2-bit build that counts modulo 4. That build brings out an ungated decode of count 3, which gives a clock at one quarter of the input frequency with a 25/75 duty cycle. The raw count is available as an output for observation. The block has no data stream, so no handshake applies.

Top module: `strobe_counter`

## Requirements
- R1: At each falling clock edge after reset, `count_o` increases by one in plain binary and wraps from its all-ones value to 0.
- R2: Raising `rst` clears `count_o` to 0 at once, without waiting for a clock edge.
- R3: In the low clock phase, `strb_two_o` is high exactly when `count_o` is 2, `strb_three_o` exactly when it is 3, and `strb_five_o` exactly when it is 5.
- R4: All three strobes are low throughout every high clock phase.
- R5: While `rst` is high, all three strobes stay low, even during the low clock phase.
- R6: In the 3-bit build, each strobe pulses exactly once every 8 clock cycles.
- R7: At most one strobe is high at any time.
- R8: With `CNT_W` = 2, `count_o` wraps from 3 to 0 and `strb_five_o` is always low. `quarter_clk_o` is high for the whole clock period in which the count is 3, which gives one high period in every four (25% duty).
- R9: With `CNT_W` = 3, `quarter_clk_o` is held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on its falling edge |
| rst | input | 1 | Asynchronous active-high clear of the counter |
| count_o | output | CNT_W | Present count, for observation |
| strb_two_o | output | 1 | High in the low phase while the count is 2 |
| strb_three_o | output | 1 | High in the low phase while the count is 3 |
| strb_five_o | output | 1 | High in the low phase while the count is 5 (always low when CNT_W is 2) |
| quarter_clk_o | output | 1 | Ungated decode of count 3 in the 2-bit build; low otherwise |

## Verification
The hardest case to reach is reset arriving in the middle of a low phase while a strobe is high. There, the asynchronous clear must drop both the count and the strobe before any clock edge occurs. To get there, the stimulus runs the counter until the count reaches 5. It confirms that `strb_five_o` is up in that low phase, raises `rst` partway through the same phase, and samples the outputs half a nanosecond later. After reset is released, the expected-value queue is reloaded, and the counter must restart cleanly from 1.

// File: rtl/strobe_counter_pkg.sv
`timescale 1ns/1ps
package strobe_counter_pkg;

  localparam int unsigned NUM_TAPS = 3;

  // Count value watched by each strobe, by tap index.
  function automatic int unsigned tap_value(input int unsigned idx);
    case (idx)
      0:       return 2;
      1:       return 3;
      default: return 5;
    endcase
  endfunction

  // A tap exists only if its value can be held by the counter.
  function automatic bit tap_fits(input int unsigned idx, input int unsigned width);
    return tap_value(idx) < (32'd1 << width);
  endfunction

endpackage

// File: rtl/sc_fall_counter.sv
`timescale 1ns/1ps
module sc_fall_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] STEP = W'(1);

  // State moves on the back edge of the clock, as a master-slave stage would.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + STEP;
  end

endmodule

// File: rtl/sc_value_match.sv
`timescale 1ns/1ps
module sc_value_match #(
  parameter int unsigned W     = 3,
  parameter int unsigned VALUE = 0
) (
  input  logic [W-1:0] cnt,
  output logic         hit
);

  localparam logic [W-1:0] TARGET = W'(VALUE);

  always_comb hit = (cnt == TARGET);

endmodule

// File: rtl/sc_phase_gate.sv
`timescale 1ns/1ps
module sc_phase_gate #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  output logic [N-1:0] strb
);

  logic open_phase;

  // Pass the decodes only in the low half of the clock, and never during reset.
  always_comb open_phase = ~clk & ~rst;
  always_comb strb       = hit & {N{open_phase}};

endmodule

// File: rtl/strobe_counter.sv
`timescale 1ns/1ps
module strobe_counter
  import strobe_counter_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count_o,
  output logic             strb_two_o,
  output logic             strb_three_o,
  output logic             strb_five_o,
  output logic             quarter_clk_o
);

  localparam int unsigned QUARTER_VALUE = 3;

  logic [CNT_W-1:0]    cnt_q;
  logic [NUM_TAPS-1:0] tap_hit;
  logic [NUM_TAPS-1:0] tap_strb;

  sc_fall_counter #(.W(CNT_W)) counter_i (
    .clk (clk),
    .rst (rst),
    .cnt (cnt_q)
  );

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    if (tap_fits(t, CNT_W)) begin : g_live
      sc_value_match #(.W(CNT_W), .VALUE(tap_value(t))) match_i (
        .cnt (cnt_q),
        .hit (tap_hit[t])
      );
    end else begin : g_absent
      assign tap_hit[t] = 1'b0;
    end
  end

  sc_phase_gate #(.N(NUM_TAPS)) gate_i (
    .clk  (clk),
    .rst  (rst),
    .hit  (tap_hit),
    .strb (tap_strb)
  );

  if (CNT_W == 2) begin : g_quarter
    sc_value_match #(.W(CNT_W), .VALUE(QUARTER_VALUE)) quarter_i (
      .cnt (cnt_q),
      .hit (quarter_clk_o)
    );
  end else begin : g_no_quarter
    assign quarter_clk_o = 1'b0;
  end

  assign count_o      = cnt_q;
  assign strb_two_o   = tap_strb[0];
  assign strb_three_o = tap_strb[1];
  assign strb_five_o  = tap_strb[2];

endmodule

// File: rtl/strobe_counter_chk.sv
`timescale 1ns/1ps
module strobe_counter_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_o,
  input logic             strb_two_o,
  input logic             strb_three_o,
  input logic             strb_five_o,
  input logic             quarter_clk_o
);

  logic running;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) running <= 1'b0;
    else     running <= 1'b1;
  end

  // Sampled at the rising edge, the preponed values belong to the low phase.
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    running |-> count_o == (CNT_W'($past(count_o)) + CNT_W'(1)));

  p_reset_clears_r2: assert property (@(posedge clk)
    rst |-> count_o == '0);

  p_two_match_r3: assert property (@(posedge clk) disable iff (rst)
    strb_two_o == (count_o == CNT_W'(2)));

  p_three_match_r3: assert property (@(posedge clk) disable iff (rst)
    strb_three_o == (count_o == CNT_W'(3)));

  // Sampled at the falling edge, the preponed values belong to the high phase.
  p_high_phase_quiet_r4: assert property (@(negedge clk) disable iff (rst)
    !(strb_two_o | strb_three_o | strb_five_o));

  p_reset_quiet_r5: assert property (@(posedge clk)
    rst |-> !(strb_two_o | strb_three_o | strb_five_o));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb_two_o, strb_three_o, strb_five_o}));

  if (CNT_W == 2) begin : g_w2
    p_no_five_r8: assert property (@(posedge clk) disable iff (rst)
      !strb_five_o);
    p_quarter_single_r8: assert property (@(posedge clk) disable iff (rst)
      running && $past(quarter_clk_o) |-> !quarter_clk_o);
  end else begin : g_w3
    p_five_match_r3: assert property (@(posedge clk) disable iff (rst)
      strb_five_o == (count_o == CNT_W'(5)));
    p_quarter_low_r9: assert property (@(posedge clk) disable iff (rst)
      !quarter_clk_o);
  end

endmodule

bind strobe_counter strobe_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .count_o       (count_o),
  .strb_two_o    (strb_two_o),
  .strb_three_o  (strb_three_o),
  .strb_five_o   (strb_five_o),
  .quarter_clk_o (quarter_clk_o)
);

// File: tb/strobe_counter_tb_top.sv
`timescale 1ns/1ps
module strobe_counter_tb_top;

  typedef struct {
    int c3;
    int s3;   // {five, three, two}
    int c2;
    int s2;
    int q2;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic [2:0] cnt3;
  logic       a2, a3, a5, aq;
  logic [1:0] cnt2;
  logic       b2, b3, b5, bq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  exp_t sb_q[$];
  int   model3 = 0;
  int   model2 = 0;

  always #2.5 clk = ~clk;

  strobe_counter #(.CNT_W(3)) dut_i (
    .clk(clk), .rst(rst), .count_o(cnt3),
    .strb_two_o(a2), .strb_three_o(a3), .strb_five_o(a5), .quarter_clk_o(aq));

  strobe_counter #(.CNT_W(2)) dut2_i (
    .clk(clk), .rst(rst), .count_o(cnt2),
    .strb_two_o(b2), .strb_three_o(b3), .strb_five_o(b5), .quarter_clk_o(bq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: expected values for the next n low phases, derived from the requirements.
  task automatic push_expect(input int n);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      model3 = (model3 + 1) % 8;
      model2 = (model2 + 1) % 4;
      e.c3 = model3;
      e.s3 = ((model3 == 5) ? 4 : 0) | ((model3 == 3) ? 2 : 0) | ((model3 == 2) ? 1 : 0);
      e.c2 = model2;
      e.s2 = ((model2 == 3) ? 2 : 0) | ((model2 == 2) ? 1 : 0);
      e.q2 = (model2 == 3) ? 1 : 0;
      sb_q.push_back(e);
    end
  endtask

  // Monitor: one popped item per cycle, checked in its low and then its high phase.
  task automatic monitor(input int n);
    int last_pulse [3];
    int qhigh = 0;
    int samples = 0;
    int pulses [3];
    for (int k = 0; k < 3; k++) begin last_pulse[k] = -1; pulses[k] = 0; end
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int act3;
      int act2;
      @(negedge clk); #1.25;
      e = sb_q.pop_front();
      act3 = {29'd0, a5, a3, a2};
      act2 = {29'd0, b5, b3, b2};
      check(cnt3 == 3'(e.c3), "R1 count", int'(cnt3), e.c3);
      check(act3 == e.s3, "R3 strobes low phase", act3, e.s3);
      check($countones({a5, a3, a2}) <= 1, "R7 one strobe", act3, e.s3);
      check(cnt2 == 2'(e.c2), "R8 count mod4", int'(cnt2), e.c2);
      check(act2 == e.s2, "R8 strobes 2-bit", act2, e.s2);
      check(aq == 1'b0, "R9 quarter low", int'(aq), 0);
      for (int k = 0; k < 3; k++) begin
        if (act3[k]) begin
          if (last_pulse[k] >= 0)
            check(i - last_pulse[k] == 8, "R6 strobe spacing", i - last_pulse[k], 8);
          last_pulse[k] = i;
          pulses[k]++;
        end
      end
      samples++; qhigh += int'(bq);
      check(bq == 1'(e.q2), "R8 quarter low phase", int'(bq), e.q2);
      @(posedge clk); #1.25;
      check({a5, a3, a2} == 3'b000, "R4 high phase quiet", int'({a5, a3, a2}), 0);
      check({b5, b3, b2} == 3'b000, "R4 high phase quiet 2-bit", int'({b5, b3, b2}), 0);
      check(cnt3 == 3'(e.c3), "R1 count held in high phase", int'(cnt3), e.c3);
      samples++; qhigh += int'(bq);
      check(bq == 1'(e.q2), "R8 quarter high phase", int'(bq), e.q2);
    end
    if (n >= 24) begin
      for (int k = 0; k < 3; k++)
        check(pulses[k] >= 3, "R6 pulse count", pulses[k], 3);
      check(qhigh * 4 == samples, "R8 quarter duty", qhigh * 4, samples);
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state, observed during a low phase (R2, R5).
    repeat (2) @(posedge clk);
    @(negedge clk); #1.25;
    check(cnt3 == 3'd0, "R2 reset count", int'(cnt3), 0);
    check({a5, a3, a2} == 3'b000, "R5 strobes in reset", int'({a5, a3, a2}), 0);
    check(cnt2 == 2'd0, "R2 reset count 2-bit", int'(cnt2), 0);
    @(posedge clk); #1.25;
    rst = 1'b0;
    model3 = 0; model2 = 0;
    push_expect(28);
    monitor(28);

    // Count is 5 in this low phase: strobe up, then asynchronous reset.
    @(negedge clk); #1.25;
    check(a5 == 1'b1, "R3 five strobe before reset", int'(a5), 1);
    check(b5 == 1'b0, "R8 no five strobe 2-bit", int'(b5), 0);
    rst = 1'b1;
    #0.5;
    check(cnt3 == 3'd0, "R2 async clear", int'(cnt3), 0);
    check(cnt2 == 2'd0, "R2 async clear 2-bit", int'(cnt2), 0);
    check({a5, a3, a2} == 3'b000, "R5 strobes drop on reset", int'({a5, a3, a2}), 0);
    @(posedge clk); #1.25;
    @(negedge clk); #1.25;
    check(cnt3 == 3'd0, "R2 held through edge", int'(cnt3), 0);
    check({a5, a3, a2} == 3'b000, "R5 strobes low in reset", int'({a5, a3, a2}), 0);
    @(posedge clk); #1.25;
    rst = 1'b0;
    model3 = 0; model2 = 0;
    push_expect(12);
    monitor(12);
    check(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule